// File: doc/BRIEF.md
# Sixteen-bit subtract and logic execute unit

This block is the execute step for one row of opcodes in a 16-bit register machine. The row holds subtractions and bitwise masking operations. A row-select input picks the subtract row or the logic row, and a 2-bit prefix mode picks the variant inside the row. The unit takes the source register value, the operand register value, a 4-bit field that serves as either an immediate or a register selector, and the current carry flag. It returns a result with a destination write strobe, the sign, zero, carry and overflow flags with a separate update strobe for each flag, a program-counter step pulse, and a request to clear the prefix mode.

The unit registers its outputs once. An operation issued in one cycle shows its effect after the next rising clock edge. A flag output keeps its value until its own update strobe fires. The result output keeps its value until a destination write occurs.

Top module: `subx_exec`

## Requirements
- R1: After reset, all strobes are 0: dest_we, s_we, z_we, c_we, v_we, pc_step and prefix_clr. The result is 0 and all four flags are 0.
- R2: With row_logic=0 and mode=0, the result is src_val minus opd_val modulo 2^16, and dest_we is 1.
- R3: With row_logic=0 and mode=1, the result is src_val minus opd_val minus (1 minus carry_in). A set carry_in therefore means no borrow.
- R4: With row_logic=0 and mode=2, the subtrahend is sel zero-extended to 16 bits, so it ranges from 0 to 15. opd_val is ignored.
- R5: With row_logic=0 and mode=3, a compare is made against opd_val. All four flag strobes are 1, dest_we is 0, and the result output does not change.
- R6: For every subtract-row operation, c_we is 1. The carry flag is 1 exactly when the unsigned difference, including any borrow, is non-negative.
- R7: For every subtract-row operation, v_we is 1. The overflow flag is bit 15 of (source XOR subtrahend) AND (source XOR 16-bit difference). For mode 2 the subtrahend is the immediate.
- R8: Whenever s_we or z_we fires, the sign flag is bit 15 of the computed value and the zero flag is 1 when all 16 bits of that value are 0.
- R9: With row_logic=1 and sel nonzero, the four modes produce these results, each with dest_we=1: mode 0 gives src AND opd, mode 1 gives src AND NOT opd, mode 2 gives src AND zero-extended sel, and mode 3 gives src AND NOT zero-extended sel. s_we and z_we are 1. c_we and v_we are 0, and the carry and overflow flags keep their values.
- R10: With row_logic=1 and sel=0, an issued operation has no effect. Every strobe stays 0, including pc_step and prefix_clr, and the result and flags do not change.
- R11: Every other issued operation produces pc_step=1 and prefix_clr=1 for exactly the one cycle after issue.
- R12: In a cycle with issue=0, all strobes in the next cycle are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| issue | input | 1 | An operation is presented this cycle |
| row_logic | input | 1 | 0 selects the subtract row, 1 selects the logic row |
| mode | input | 2 | Prefix mode picking the variant |
| sel | input | 4 | Immediate value or register selector |
| src_val | input | 16 | Source register value |
| opd_val | input | 16 | Operand register value |
| carry_in | input | 1 | Current carry flag |
| result | output | 16 | Last written result |
| dest_we | output | 1 | Destination register write strobe |
| flag_s | output | 1 | Sign flag |
| flag_z | output | 1 | Zero flag |
| flag_c | output | 1 | Carry flag |
| flag_v | output | 1 | Overflow flag |
| s_we | output | 1 | Sign flag update strobe |
| z_we | output | 1 | Zero flag update strobe |
| c_we | output | 1 | Carry flag update strobe |
| v_we | output | 1 | Overflow flag update strobe |
| pc_step | output | 1 | Program counter advance pulse |
| prefix_clr | output | 1 | Request to return prefix mode to 0 |

## Verification
The bench aims at the borrow edges of subtract-with-carry, such as 0 minus 0 with carry clear, and 0x0000 minus 0xFFFF. A design that used the carry itself as the borrow, or dropped the seventeenth bit, would report the wrong carry there. The bench crosses the signed boundary at 0x8000 and 0x7FFF, where a wrong overflow term would fail. It runs compares to catch a stray destination write, and logic operations to catch a carry or overflow flag that gets changed. It also issues logic operations with selector 0, where a design that treats that value as a normal operation would step the program counter or write the result.

// File: rtl/subx_pkg.sv
package subx_pkg;

  typedef enum logic [1:0] {
    MD_PLAIN = 2'd0,
    MD_ALTA  = 2'd1,
    MD_IMM   = 2'd2,
    MD_ALTB  = 2'd3
  } row_mode_e;

  typedef struct packed {
    logic s;
    logic z;
    logic c;
    logic v;
  } flag4_t;

endpackage

// File: rtl/subx_sub_path.sv
module subx_sub_path
  import subx_pkg::*;
#(
  parameter int DW = 16,
  parameter int IW = 4
) (
  input  logic [DW-1:0] src_val,
  input  logic [DW-1:0] opd_val,
  input  logic [IW-1:0] sel,
  input  logic [1:0]    mode,
  input  logic          carry_in,
  output logic [DW-1:0] diff,
  output flag4_t        flags,
  output logic          writes_dest
);

  localparam int PAD = DW - IW;

  function automatic logic [DW:0] wide_sub(input logic [DW-1:0] a,
                                           input logic [DW-1:0] b,
                                           input logic          borrow);
    return {1'b0, a} - {1'b0, b} - {{DW{1'b0}}, borrow};
  endfunction

  function automatic logic ovf_of(input logic [DW-1:0] a,
                                  input logic [DW-1:0] b,
                                  input logic [DW-1:0] d);
    logic [DW-1:0] t;
    t = (a ^ b) & (a ^ d);
    return t[DW-1];
  endfunction

  row_mode_e     md;
  logic [DW-1:0] subtrahend;
  logic          borrow_in;
  logic [DW:0]   full;

  always_comb begin
    md          = row_mode_e'(mode);
    subtrahend  = (md == MD_IMM) ? {{PAD{1'b0}}, sel} : opd_val;
    borrow_in   = (md == MD_ALTA) ? ~carry_in : 1'b0;
    full        = wide_sub(src_val, subtrahend, borrow_in);
    diff        = full[DW-1:0];
    flags.s     = full[DW-1];
    flags.z     = (full[DW-1:0] == '0);
    flags.c     = ~full[DW];
    flags.v     = ovf_of(src_val, subtrahend, full[DW-1:0]);
    writes_dest = (md != MD_ALTB);
  end

endmodule

// File: rtl/subx_logic_path.sv
module subx_logic_path
  import subx_pkg::*;
#(
  parameter int DW = 16,
  parameter int IW = 4
) (
  input  logic [DW-1:0] src_val,
  input  logic [DW-1:0] opd_val,
  input  logic [IW-1:0] sel,
  input  logic [1:0]    mode,
  output logic [DW-1:0] masked,
  output logic          sign_o,
  output logic          zero_o,
  output logic          is_null
);

  localparam int PAD = DW - IW;

  function automatic logic [DW-1:0] mask_op(input logic [DW-1:0] a,
                                            input logic [DW-1:0] m,
                                            input logic          invert);
    return invert ? (a & ~m) : (a & m);
  endfunction

  logic [DW-1:0] mask_src;

  always_comb begin
    mask_src = mode[1] ? {{PAD{1'b0}}, sel} : opd_val;
    masked   = mask_op(src_val, mask_src, mode[0]);
    sign_o   = masked[DW-1];
    zero_o   = (masked == '0);
    is_null  = (sel == '0);
  end

endmodule

// File: rtl/subx_out_stage.sv
module subx_out_stage
  import subx_pkg::*;
#(
  parameter int DW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          live,
  input  logic [DW-1:0] res_d,
  input  logic          res_we_d,
  input  flag4_t        flag_d,
  input  flag4_t        flag_we_d,
  output logic [DW-1:0] res_q,
  output logic          res_we_q,
  output flag4_t        flag_q,
  output flag4_t        flag_we_q,
  output logic          step_q
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      res_q     <= '0;
      res_we_q  <= 1'b0;
      flag_q    <= '0;
      flag_we_q <= '0;
      step_q    <= 1'b0;
    end else begin
      res_we_q  <= live & res_we_d;
      flag_we_q <= live ? flag_we_d : '0;
      step_q    <= live;
      if (live && res_we_d) res_q <= res_d;
      if (live && flag_we_d.s) flag_q.s <= flag_d.s;
      if (live && flag_we_d.z) flag_q.z <= flag_d.z;
      if (live && flag_we_d.c) flag_q.c <= flag_d.c;
      if (live && flag_we_d.v) flag_q.v <= flag_d.v;
    end
  end

endmodule

// File: rtl/subx_exec.sv
module subx_exec
  import subx_pkg::*;
#(
  parameter int DW = 16,
  parameter int IW = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          issue,
  input  logic          row_logic,
  input  logic [1:0]    mode,
  input  logic [IW-1:0] sel,
  input  logic [DW-1:0] src_val,
  input  logic [DW-1:0] opd_val,
  input  logic          carry_in,
  output logic [DW-1:0] result,
  output logic          dest_we,
  output logic          flag_s,
  output logic          flag_z,
  output logic          flag_c,
  output logic          flag_v,
  output logic          s_we,
  output logic          z_we,
  output logic          c_we,
  output logic          v_we,
  output logic          pc_step,
  output logic          prefix_clr
);

  logic [DW-1:0] sub_diff;
  flag4_t        sub_flags;
  logic          sub_writes;
  logic [DW-1:0] log_res;
  logic          log_sign, log_zero, log_null;

  logic          op_live;
  logic [DW-1:0] res_mux;
  logic          res_we_mux;
  flag4_t        flag_mux, flag_we_mux;
  flag4_t        flag_reg, flag_we_reg;

  subx_sub_path #(.DW(DW), .IW(IW)) u_sub (
    .src_val(src_val), .opd_val(opd_val), .sel(sel), .mode(mode),
    .carry_in(carry_in), .diff(sub_diff), .flags(sub_flags),
    .writes_dest(sub_writes)
  );

  subx_logic_path #(.DW(DW), .IW(IW)) u_log (
    .src_val(src_val), .opd_val(opd_val), .sel(sel), .mode(mode),
    .masked(log_res), .sign_o(log_sign), .zero_o(log_zero),
    .is_null(log_null)
  );

  always_comb begin
    op_live = issue & ~(row_logic & log_null);
    if (row_logic) begin
      res_mux     = log_res;
      res_we_mux  = 1'b1;
      flag_mux    = '{s: log_sign, z: log_zero, c: 1'b0, v: 1'b0};
      flag_we_mux = '{s: 1'b1, z: 1'b1, c: 1'b0, v: 1'b0};
    end else begin
      res_mux     = sub_diff;
      res_we_mux  = sub_writes;
      flag_mux    = sub_flags;
      flag_we_mux = '{s: 1'b1, z: 1'b1, c: 1'b1, v: 1'b1};
    end
  end

  subx_out_stage #(.DW(DW)) u_out (
    .clk(clk), .rst_n(rst_n), .live(op_live),
    .res_d(res_mux), .res_we_d(res_we_mux),
    .flag_d(flag_mux), .flag_we_d(flag_we_mux),
    .res_q(result), .res_we_q(dest_we),
    .flag_q(flag_reg), .flag_we_q(flag_we_reg),
    .step_q(pc_step)
  );

  assign prefix_clr = pc_step;
  assign flag_s = flag_reg.s;
  assign flag_z = flag_reg.z;
  assign flag_c = flag_reg.c;
  assign flag_v = flag_reg.v;
  assign s_we   = flag_we_reg.s;
  assign z_we   = flag_we_reg.z;
  assign c_we   = flag_we_reg.c;
  assign v_we   = flag_we_reg.v;

endmodule

// File: rtl/subx_exec_chk.sv
module subx_exec_chk #(
  parameter int DW = 16,
  parameter int IW = 4
) (
  input logic          clk,
  input logic          rst_n,
  input logic          issue,
  input logic          row_logic,
  input logic [1:0]    mode,
  input logic [IW-1:0] sel,
  input logic [DW-1:0] result,
  input logic          dest_we,
  input logic          flag_s,
  input logic          flag_z,
  input logic          flag_c,
  input logic          flag_v,
  input logic          s_we,
  input logic          z_we,
  input logic          c_we,
  input logic          v_we,
  input logic          pc_step,
  input logic          prefix_clr
);

  // R11
  step_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (issue && !(row_logic && sel == '0)) |=> (pc_step && prefix_clr));

  // R10
  null_op_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (issue && row_logic && sel == '0) |=>
      (!pc_step && !dest_we && !s_we && !c_we && $stable(result)));

  // R5
  cmp_no_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (issue && !row_logic && mode == 2'd3) |=>
      (!dest_we && c_we && v_we && $stable(result)));

  // R9
  logic_keeps_cv_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (issue && row_logic && sel != '0) |=>
      (!c_we && !v_we && $stable(flag_c) && $stable(flag_v)));

  // R8
  sz_match_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (dest_we && z_we) |-> (flag_z == (result == '0) && flag_s == result[DW-1]));

  // R12
  idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !issue |=> (!dest_we && !s_we && !z_we && !c_we && !v_we && !pc_step));

endmodule

bind subx_exec subx_exec_chk #(.DW(DW), .IW(IW)) u_chk (.*);

// File: tb/subx_exec_test.sv
module subx_exec_test;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        issue = 1'b0, row_logic = 1'b0, carry_in = 1'b0;
  logic [1:0]  mode = '0;
  logic [3:0]  sel = '0;
  logic [15:0] src_val = '0, opd_val = '0;
  logic [15:0] result;
  logic dest_we, flag_s, flag_z, flag_c, flag_v;
  logic s_we, z_we, c_we, v_we, pc_step, prefix_clr;

  int errors = 0;
  int checks = 0;

  logic [15:0] m_res;
  logic m_s, m_z, m_c, m_v;

  always #10 clk = ~clk;

  subx_exec uut (.*);

  task automatic check(input string tag, input logic [31:0] got, input logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s: got %h expected %h", tag, got, exp);
    end
  endtask

  function automatic logic [6:0] strobes();
    return {dest_we, s_we, z_we, c_we, v_we, pc_step, prefix_clr};
  endfunction

  task automatic run_op(input logic rl, input logic [1:0] md, input logic [3:0] sl,
                        input logic [15:0] a, input logic [15:0] b, input logic ci);
    logic [15:0] sb, d;
    int full;
    logic [6:0] exp_st;
    string rtag;
    row_logic = rl; mode = md; sel = sl; src_val = a; opd_val = b;
    carry_in = ci; issue = 1'b1;
    exp_st = 7'b0;
    rtag = "R2";
    if (!rl) begin
      sb = (md == 2'd2) ? {12'd0, sl} : b;
      full = int'(a) - int'(sb) - ((md == 2'd1 && !ci) ? 1 : 0);
      d = full[15:0];
      m_s = d[15]; m_z = (d == 16'd0); m_c = (full >= 0);
      m_v = ((a[15] != sb[15]) && (a[15] != d[15]));
      exp_st = {(md != 2'd3), 6'b111111};
      if (md != 2'd3) m_res = d;
      rtag = (md == 2'd0) ? "R2" : (md == 2'd1) ? "R3" : (md == 2'd2) ? "R4" : "R5";
    end else if (sl != 4'd0) begin
      sb = md[1] ? {12'd0, sl} : b;
      if (md[0]) sb = ~sb;
      d = a & sb;
      m_res = d; m_s = d[15]; m_z = (d == 16'd0);
      exp_st = 7'b1110011;
      rtag = "R9";
    end else begin
      rtag = "R10";
    end
    @(negedge clk);
    issue = 1'b0;
    check({rtag, "/R11 strobes"}, {25'd0, strobes()}, {25'd0, exp_st});
    check({rtag, " result"}, {16'd0, result}, {16'd0, m_res});
    check("R8 sign/zero", {30'd0, flag_s, flag_z}, {30'd0, m_s, m_z});
    check("R6 carry", {31'd0, flag_c}, {31'd0, m_c});
    check("R7 overflow", {31'd0, flag_v}, {31'd0, m_v});
  endtask

  task automatic idle_cycle();
    issue = 1'b0;
    @(negedge clk);
    check("R12 idle strobes", {25'd0, strobes()}, 32'd0);
  endtask

  initial begin
    #2_000_000;
    errors++;
    checks++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    int seed;
    seed = 32'h5a17;
    void'($urandom(seed));
    m_res = '0; m_s = 0; m_z = 0; m_c = 0; m_v = 0;
    repeat (3) @(negedge clk);
    check("R1 reset strobes", {25'd0, strobes()}, 32'd0);
    check("R1 reset result", {16'd0, result}, 32'd0);
    check("R1 reset flags", {28'd0, flag_s, flag_z, flag_c, flag_v}, 32'd0);
    rst_n = 1'b1;
    @(negedge clk);

    // directed corners
    run_op(0, 2'd1, 4'd0, 16'h0000, 16'h0000, 1'b0); // R3 borrow from 0
    run_op(0, 2'd1, 4'd0, 16'h0000, 16'hFFFF, 1'b1); // R3 no borrow
    run_op(0, 2'd1, 4'd0, 16'h0000, 16'hFFFF, 1'b0); // R6 max borrow
    run_op(0, 2'd0, 4'd0, 16'h8000, 16'h0001, 1'b0); // R7 overflow
    run_op(0, 2'd0, 4'd0, 16'h7FFF, 16'hFFFF, 1'b0); // R7 overflow up
    run_op(0, 2'd2, 4'd15, 16'h000F, 16'h1234, 1'b0); // R4 to zero
    run_op(0, 2'd2, 4'd0, 16'h0000, 16'hFFFF, 1'b0);  // R4 imm 0
    run_op(0, 2'd3, 4'd0, 16'h1234, 16'h1234, 1'b0);  // R5 equal compare
    run_op(1, 2'd0, 4'd3, 16'hF0F0, 16'h0F0F, 1'b0);  // R9 and to zero
    run_op(1, 2'd3, 4'd15, 16'h800F, 16'h0000, 1'b0); // R9 bic imm
    run_op(1, 2'd1, 4'd0, 16'hFFFF, 16'h0000, 1'b1);  // R10 null
    run_op(1, 2'd2, 4'd0, 16'h0000, 16'h0000, 1'b0);  // R10 null
    idle_cycle();

    for (int i = 0; i < 400; i++) begin
      logic [31:0] r;
      r = $urandom;
      run_op(r[0], r[2:1], r[6:3], 16'($urandom), 16'($urandom), r[7]);
      if (r[11:8] == 4'd0) idle_cycle();
    end
    idle_cycle();

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule